// File: doc/BRIEF.md
# SDRAM Burst Interrupt and Auto-Precharge Sequencer

This block sits on the controller side of a four-bank single-data-rate SDRAM. It watches the stream of column commands the controller issues (read or write, a bank number and an auto-precharge flag) and tracks, bank by bank, which burst owns the data bus at every cycle. When a new burst to one bank cuts off a burst still running on another bank, the block applies the truncation timing for that pairing of read and write. It drives the bus-direction enable, the data mask and the read and write data strobes.

Commands pass through a two-stage staging pipeline before they take effect at the memory. This gives the block two cycles of lookahead, so it can raise the data mask ahead of a write that will cut off a read. A bank whose burst was started with auto precharge begins its internal precharge at the point its burst ends, whether the burst completed or was truncated. The block pulses a per-bank precharge-start flag at that point and holds the bank busy for the row-precharge time. A command that targets a bank which cannot accept it is refused and flagged.

In the rules below, "cycle n" is the clock period that follows rising edge n. A command driven onto the inputs in cycle c is sampled at edge c+1 and takes effect ("is registered") at edge R = c+3. BL, CL, TWR and TRP denote the burst length, CAS latency, write recovery time and row-precharge time, all in clocks.

Top module: `sdrb_burst_seq`

## Requirements
- R1: After reset every bank reports idle (bank_idle all ones) and dq_drive, rd_valid, dqm, pre_start and cmd_err are all low.
- R2: A burst that nothing interrupts runs exactly BL beats. A write registered at R raises dq_drive with wr_bank set to its bank in cycles R to R+BL-1. A read registered at R raises rd_valid with rd_bank set to its bank in cycles R+CL to R+CL+BL-1.
- R3: When a read to bank m is registered at R2 while bank n is reading, bank n read data appears for the last time in cycle R2+CL-1, and bank m data fills cycles R2+CL onward.
- R4: When a write is registered at R2 while read data is still pending, rd_valid is low from cycle R2, and the write beats start in cycle R2. dqm is high in cycles R2-2 and R2-1, and is never high while dq_drive is high.
- R5: When a read is registered at R2 during a write burst, the last write beat is cycle R2-1, and the new read data starts in cycle R2+CL.
- R6: When a write to bank m is registered at R2 during a write to bank n, the last bank n beat is cycle R2-1, and bank m beats occupy cycles R2 to R2+BL-1.
- R7: A burst with auto precharge that completes untruncated pulses its bank's pre_start bit for one cycle: in cycle R+BL for a read, or in cycle R+BL+TWR for a write. A burst without auto precharge never pulses pre_start.
- R8: A truncated burst with auto precharge pulses pre_start in cycle R2+CL for a read cut by a read, in cycle R2 for a read cut by a write, and in cycle R2+TWR for a write cut by either command. A truncated burst without auto precharge sends its bank straight back to idle from cycle R2, with no pre_start.
- R9: A bank's bank_idle bit is low while it bursts, waits or precharges. It is low in the cycle its pre_start pulses, and it returns high exactly TRP cycles after that pulse.
- R10: A command registered at R is illegal if its target bank is waiting to precharge, is precharging, or is still bursting with auto precharge. An illegal command raises cmd_err in cycle R and is otherwise ignored: the burst in progress and any pending precharge continue unchanged.
- R11: dq_drive and rd_valid are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A column command is presented this cycle |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_bank | input | 2 | Target bank of the command |
| cmd_autopre | input | 1 | Command requests auto precharge |
| dq_drive | output | 1 | Controller drives the data bus; high on every write beat |
| wr_bank | output | 2 | Bank that owns the current write beat |
| rd_valid | output | 1 | Read data from the memory is valid this cycle |
| rd_bank | output | 2 | Bank that owns the current read beat |
| dqm | output | 1 | Data mask, raised ahead of a write that cuts a read |
| pre_start | output | 4 | One-cycle pulse per bank when its internal precharge begins |
| bank_idle | output | 4 | Per-bank flag: bank ready for a new burst |
| cmd_err | output | 1 | Registered command was illegal and was ignored |

## Verification
The hardest state to reach is a bank that is waiting out write recovery or precharging while a new command arrives for it. The command has to be timed against the staging delay, so that it takes effect in exactly the cycle the bank is in its pending window. The directed stimulus first issues a write with auto precharge, then aims a read at the same bank so that it lands two cycles after the burst ends. A second case sends a back-to-back read to a bank still reading with auto precharge. In both cases the bench checks that the error pulse appears, and that the original burst and its precharge cycle stay untouched. The truncation pairings are reached by spacing two commands a fixed number of cycles apart, so that each interrupt lands at a chosen beat.

// File: rtl/sdrb_pkg.sv
package sdrb_pkg;

    localparam int BANK_W = 2;

    typedef enum logic [2:0] {
        BK_IDLE,
        BK_READ,
        BK_WRITE,
        BK_PEND,
        BK_PRE
    } bank_st_e;

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic              ap;
        logic [BANK_W-1:0] bank;
    } cmd_t;

    typedef struct packed {
        logic              vld;
        logic [BANK_W-1:0] bank;
    } slot_t;

endpackage

// File: rtl/sdrb_cmd_stage.sv
module sdrb_cmd_stage
    import sdrb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  cmd_t cmd_i,
    output cmd_t cmd_o,
    output logic wr_ahead_o
);

    cmd_t st_d [DEPTH];
    cmd_t st_q [DEPTH];

    always_comb begin
        st_d[0] = cmd_i;
        for (int i = 1; i < DEPTH; i++) begin
            st_d[i] = st_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                st_q[i] <= st_d[i];
            end
        end
    end

    always_comb begin
        wr_ahead_o = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q[i].vld && st_q[i].wr) begin
                wr_ahead_o = 1'b1;
            end
        end
    end

    assign cmd_o = st_q[DEPTH-1];

endmodule

// File: rtl/sdrb_rd_pipe.sv
module sdrb_rd_pipe
    import sdrb_pkg::*;
#(
    parameter int CL = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  slot_t slot_i,
    input  logic  flush_i,
    output slot_t slot_o,
    output logic  busy_o
);

    slot_t line_d [CL];
    slot_t line_q [CL];

    always_comb begin
        for (int i = 0; i < CL; i++) begin
            if (flush_i) begin
                line_d[i] = '0;
            end else if (i == 0) begin
                line_d[i] = slot_i;
            end else begin
                line_d[i] = line_q[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CL; i++) begin
                line_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < CL; i++) begin
                line_q[i] <= line_d[i];
            end
        end
    end

    always_comb begin
        busy_o = 1'b0;
        for (int i = 0; i < CL; i++) begin
            busy_o = busy_o | line_q[i].vld;
        end
    end

    assign slot_o = line_q[CL-1];

endmodule

// File: rtl/sdrb_bank.sv
module sdrb_bank
    import sdrb_pkg::*;
#(
    parameter int IDX = 0,
    parameter int BL  = 4,
    parameter int CL  = 2,
    parameter int TWR = 2,
    parameter int TRP = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  cmd_t     cmd_i,
    input  logic     cmd_ok_i,
    output bank_st_e st_o,
    output logic     ap_o,
    output logic     rd_slot_o,
    output logic     wr_slot_o,
    output logic     pre_o
);

    localparam int CW    = (BL > 1) ? $clog2(BL) : 1;
    localparam int MAXT1 = (CL > TWR) ? CL : TWR;
    localparam int MAXT  = (MAXT1 > TRP) ? MAXT1 : TRP;
    localparam int TW    = $clog2(MAXT + 1);
    localparam logic [CW-1:0] LAST   = CW'(BL - 1);
    localparam logic [TW-1:0] CL_LD  = TW'(CL - 1);
    localparam logic [TW-1:0] TWR_LD = TW'(TWR - 1);
    localparam logic [TW-1:0] TRP_LD = TW'(TRP - 1);

    typedef struct packed {
        bank_st_e      st;
        logic          ap;
        logic [CW-1:0] cnt;
        logic [TW-1:0] tmr;
        logic          pre;
    } bk_t;

    bk_t  d, q;
    logic hit, other;

    always_comb begin
        d     = q;
        d.pre = 1'b0;
        hit   = cmd_ok_i && (cmd_i.bank == BANK_W'(IDX));
        other = cmd_ok_i && !hit;
        case (q.st)
            BK_IDLE: begin
                if (hit) begin
                    d.st  = cmd_i.wr ? BK_WRITE : BK_READ;
                    d.cnt = '0;
                    d.ap  = cmd_i.ap;
                end
            end
            BK_READ, BK_WRITE: begin
                if (hit) begin
                    d.st  = cmd_i.wr ? BK_WRITE : BK_READ;
                    d.cnt = '0;
                    d.ap  = cmd_i.ap;
                end else if (other) begin
                    if (!q.ap) begin
                        d.st = BK_IDLE;
                    end else if (q.st == BK_READ && cmd_i.wr) begin
                        d.st  = BK_PRE;
                        d.tmr = TRP_LD;
                        d.pre = 1'b1;
                    end else if (q.st == BK_READ) begin
                        d.st  = BK_PEND;
                        d.tmr = CL_LD;
                    end else begin
                        d.st  = BK_PEND;
                        d.tmr = TWR_LD;
                    end
                end else if (q.cnt == LAST) begin
                    if (!q.ap) begin
                        d.st = BK_IDLE;
                    end else if (q.st == BK_READ) begin
                        d.st  = BK_PRE;
                        d.tmr = TRP_LD;
                        d.pre = 1'b1;
                    end else begin
                        d.st  = BK_PEND;
                        d.tmr = TWR_LD;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            BK_PEND: begin
                if (q.tmr == '0) begin
                    d.st  = BK_PRE;
                    d.tmr = TRP_LD;
                    d.pre = 1'b1;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            BK_PRE: begin
                if (q.tmr == '0) begin
                    d.st = BK_IDLE;
                    d.ap = 1'b0;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            default: d.st = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: BK_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign st_o      = q.st;
    assign ap_o      = q.ap;
    assign rd_slot_o = (q.st == BK_READ);
    assign wr_slot_o = (q.st == BK_WRITE);
    assign pre_o     = q.pre;

endmodule

// File: rtl/sdrb_burst_seq.sv
module sdrb_burst_seq
    import sdrb_pkg::*;
#(
    parameter int BL  = 4,
    parameter int CL  = 2,
    parameter int TWR = 2,
    parameter int TRP = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [BANK_W-1:0] cmd_bank,
    input  logic              cmd_autopre,
    output logic              dq_drive,
    output logic [BANK_W-1:0] wr_bank,
    output logic              rd_valid,
    output logic [BANK_W-1:0] rd_bank,
    output logic              dqm,
    output logic [(1<<BANK_W)-1:0] pre_start,
    output logic [(1<<BANK_W)-1:0] bank_idle,
    output logic              cmd_err
);

    localparam int NUM_BANKS   = 1 << BANK_W;
    localparam int STAGE_DEPTH = 2;

    typedef struct packed {
        logic err;
    } top_t;

    cmd_t     cmd_in, cmd_s;
    logic     wr_ahead;
    bank_st_e bk_st [NUM_BANKS];
    logic [NUM_BANKS-1:0] bk_ap, bk_rd, bk_wr, bk_pre;
    logic     illegal, cmd_ok, flush;
    slot_t    rd_slot, wr_slot, rd_out;
    logic     pipe_busy, rd_active;
    top_t     t_d, t_q;

    assign cmd_in = '{vld: cmd_valid, wr: cmd_write, ap: cmd_autopre, bank: cmd_bank};

    sdrb_cmd_stage #(.DEPTH(STAGE_DEPTH)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_i      (cmd_in),
        .cmd_o      (cmd_s),
        .wr_ahead_o (wr_ahead)
    );

    always_comb begin
        bank_st_e tgt;
        tgt     = bk_st[cmd_s.bank];
        illegal = cmd_s.vld &&
                  ((tgt == BK_PEND) || (tgt == BK_PRE) ||
                   (((tgt == BK_READ) || (tgt == BK_WRITE)) && bk_ap[cmd_s.bank]));
        cmd_ok  = cmd_s.vld && !illegal;
        flush   = cmd_ok && cmd_s.wr;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        sdrb_bank #(
            .IDX (b),
            .BL  (BL),
            .CL  (CL),
            .TWR (TWR),
            .TRP (TRP)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .cmd_i     (cmd_s),
            .cmd_ok_i  (cmd_ok),
            .st_o      (bk_st[b]),
            .ap_o      (bk_ap[b]),
            .rd_slot_o (bk_rd[b]),
            .wr_slot_o (bk_wr[b]),
            .pre_o     (bk_pre[b])
        );
        assign bank_idle[b] = (bk_st[b] == BK_IDLE);
    end

    always_comb begin
        rd_slot = '0;
        wr_slot = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bk_rd[b]) begin
                rd_slot.vld  = 1'b1;
                rd_slot.bank = BANK_W'(b);
            end
            if (bk_wr[b]) begin
                wr_slot.vld  = 1'b1;
                wr_slot.bank = BANK_W'(b);
            end
        end
    end

    sdrb_rd_pipe #(.CL(CL)) u_rdpipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .slot_i  (rd_slot),
        .flush_i (flush),
        .slot_o  (rd_out),
        .busy_o  (pipe_busy)
    );

    always_comb begin
        t_d.err = illegal;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign rd_active = rd_slot.vld || pipe_busy;
    assign dqm       = rd_active && wr_ahead;
    assign dq_drive  = wr_slot.vld;
    assign wr_bank   = wr_slot.bank;
    assign rd_valid  = rd_out.vld;
    assign rd_bank   = rd_out.bank;
    assign pre_start = bk_pre;
    assign cmd_err   = t_q.err;

endmodule

// File: rtl/sdrb_burst_chk.sv
module sdrb_burst_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dq_drive,
    input logic          rd_valid,
    input logic          dqm,
    input logic [NB-1:0] pre_start,
    input logic [NB-1:0] bank_idle
);

    assert_no_bus_clash_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drive && rd_valid));

    assert_mask_off_while_writing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dq_drive |-> !dqm);

    assert_cut_read_was_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_drive && $past(rd_valid)) |-> $past(dqm));

    for (genvar b = 0; b < NB; b++) begin : g_chk
        assert_precharge_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
            pre_start[b] |-> !bank_idle[b]);

        assert_precharge_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
            pre_start[b] |=> !pre_start[b]);
    end

endmodule

bind sdrb_burst_seq sdrb_burst_chk #(.NB(NUM_BANKS)) u_chk (.*);

// File: tb/sim_sdrb_burst_seq.sv
module sim_sdrb_burst_seq;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_write = 1'b0;
    logic [1:0] cmd_bank = 2'd0;
    logic       cmd_autopre = 1'b0;
    logic       dq_drive, rd_valid, dqm, cmd_err;
    logic [1:0] wr_bank, rd_bank;
    logic [3:0] pre_start, bank_idle;

    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;

    logic       lg_rd [4096];
    logic       lg_wr [4096];
    logic       lg_dqm [4096];
    logic       lg_err [4096];
    logic [1:0] lg_rdb [4096];
    logic [1:0] lg_wrb [4096];
    logic [3:0] lg_pre [4096];
    logic [3:0] lg_idle [4096];

    sdrb_burst_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_write   (cmd_write),
        .cmd_bank    (cmd_bank),
        .cmd_autopre (cmd_autopre),
        .dq_drive    (dq_drive),
        .wr_bank     (wr_bank),
        .rd_valid    (rd_valid),
        .rd_bank     (rd_bank),
        .dqm         (dqm),
        .pre_start   (pre_start),
        .bank_idle   (bank_idle),
        .cmd_err     (cmd_err)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (cyc < 4096) begin
            lg_rd[cyc]   <= rd_valid;
            lg_rdb[cyc]  <= rd_bank;
            lg_wr[cyc]   <= dq_drive;
            lg_wrb[cyc]  <= wr_bank;
            lg_dqm[cyc]  <= dqm;
            lg_err[cyc]  <= cmd_err;
            lg_pre[cyc]  <= pre_start;
            lg_idle[cyc] <= bank_idle;
        end
    end

    task automatic chk(string tag, int cy, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s cycle %0d: got %0d expected %0d", tag, cy, got, exp);
        end
    endtask

    // encoding used for strobes: 0 = none, otherwise owning bank + 1
    function automatic int rd_enc(int cy);
        return lg_rd[cy] ? int'(lg_rdb[cy]) + 1 : 0;
    endfunction

    function automatic int wr_enc(int cy);
        return lg_wr[cy] ? int'(lg_wrb[cy]) + 1 : 0;
    endfunction

    task automatic wait_cyc(int c);
        while (cyc < c) @(negedge clk);
    endtask

    // inputs driven in cycle c take effect at edge c+3
    task automatic issue(int c, bit wr, int bk, bit ap);
        wait_cyc(c);
        cmd_valid   = 1'b1;
        cmd_write   = wr;
        cmd_bank    = bk[1:0];
        cmd_autopre = ap;
        @(negedge clk);
        cmd_valid   = 1'b0;
        cmd_write   = 1'b0;
        cmd_autopre = 1'b0;
    endtask

    task automatic t_reset();
        wait_cyc(6);
        chk("R1 idle", 6, int'(bank_idle), 15);
        chk("R1 strobes", 6, int'({dq_drive, rd_valid, dqm, cmd_err}), 0);
        chk("R1 pre_start", 6, int'(pre_start), 0);
    endtask

    task automatic t_plain_read();
        int r = 23;
        issue(20, 1'b0, 1, 1'b0);
        wait_cyc(r + 12);
        chk("R2 read before", r + 1, rd_enc(r + 1), 0);
        for (int k = 2; k < 6; k++) chk("R2 read beat", r + k, rd_enc(r + k), 2);
        chk("R2 read after", r + 6, rd_enc(r + 6), 0);
        for (int k = 0; k < 10; k++) begin
            chk("R7 no precharge without ap", r + k, int'(lg_pre[r + k]), 0);
            chk("R4 no mask without write", r + k, int'(lg_dqm[r + k]), 0);
        end
        chk("R9 busy while reading", r, int'(lg_idle[r][1]), 0);
        chk("R8 idle after plain burst", r + 4, int'(lg_idle[r + 4][1]), 1);
    endtask

    task automatic t_write_ap();
        int r = 53;
        issue(50, 1'b1, 2, 1'b1);
        wait_cyc(r + 12);
        chk("R2 write before", r - 1, wr_enc(r - 1), 0);
        for (int k = 0; k < 4; k++) chk("R2 write beat", r + k, wr_enc(r + k), 3);
        chk("R2 write after", r + 4, wr_enc(r + 4), 0);
        chk("R7 write ap early", r + 5, int'(lg_pre[r + 5]), 0);
        chk("R7 write ap start", r + 6, int'(lg_pre[r + 6]), 4);
        chk("R7 single pulse", r + 7, int'(lg_pre[r + 7]), 0);
        chk("R9 still precharging", r + 8, int'(lg_idle[r + 8][2]), 0);
        chk("R9 idle after trp", r + 9, int'(lg_idle[r + 9][2]), 1);
    endtask

    task automatic t_read_by_read();
        int r1 = 93;
        int r2 = 95;
        issue(90, 1'b0, 0, 1'b1);
        issue(92, 1'b0, 1, 1'b0);
        wait_cyc(r2 + 12);
        chk("R3 old data", r1 + 2, rd_enc(r1 + 2), 1);
        chk("R3 old last", r2 + 1, rd_enc(r2 + 1), 1);
        for (int k = 2; k < 6; k++) chk("R3 new data", r2 + k, rd_enc(r2 + k), 2);
        chk("R3 after", r2 + 6, rd_enc(r2 + 6), 0);
        chk("R8 rr early", r2 + 1, int'(lg_pre[r2 + 1]), 0);
        chk("R8 rr start", r2 + 2, int'(lg_pre[r2 + 2]), 1);
        chk("R9 rr busy", r2 + 4, int'(lg_idle[r2 + 4][0]), 0);
        chk("R9 rr idle", r2 + 5, int'(lg_idle[r2 + 5][0]), 1);
    endtask

    task automatic t_read_by_write();
        int r1 = 133;
        int r2 = 136;
        issue(130, 1'b0, 0, 1'b1);
        issue(133, 1'b1, 3, 1'b1);
        wait_cyc(r2 + 12);
        chk("R4 read before cut", r2 - 1, rd_enc(r2 - 1), 1);
        for (int k = 0; k < 7; k++) chk("R4 read cut", r2 + k, rd_enc(r2 + k), 0);
        chk("R4 mask before", r2 - 3, int'(lg_dqm[r2 - 3]), 0);
        chk("R4 mask lead 2", r2 - 2, int'(lg_dqm[r2 - 2]), 1);
        chk("R4 mask lead 1", r2 - 1, int'(lg_dqm[r2 - 1]), 1);
        chk("R4 mask off", r2, int'(lg_dqm[r2]), 0);
        for (int k = 0; k < 4; k++) chk("R4 write beat", r2 + k, wr_enc(r2 + k), 4);
        chk("R4 write end", r2 + 4, wr_enc(r2 + 4), 0);
        chk("R8 rw start", r2, int'(lg_pre[r2]), 1);
        chk("R7 write ap bank3", r2 + 6, int'(lg_pre[r2 + 6]), 8);
        chk("R9 rw busy", r2 + 2, int'(lg_idle[r2 + 2][0]), 0);
        chk("R9 rw idle", r2 + 3, int'(lg_idle[r2 + 3][0]), 1);
    endtask

    task automatic t_write_by_read();
        int r1 = 173;
        int r2 = 175;
        issue(170, 1'b1, 1, 1'b1);
        issue(172, 1'b0, 2, 1'b0);
        wait_cyc(r2 + 12);
        chk("R5 write beat", r1, wr_enc(r1), 2);
        chk("R5 last write", r2 - 1, wr_enc(r2 - 1), 2);
        chk("R5 write ended", r2, wr_enc(r2), 0);
        chk("R5 read gap", r2 + 1, rd_enc(r2 + 1), 0);
        for (int k = 2; k < 6; k++) chk("R5 read beat", r2 + k, rd_enc(r2 + k), 3);
        chk("R5 read after", r2 + 6, rd_enc(r2 + 6), 0);
        chk("R8 wr early", r2 + 1, int'(lg_pre[r2 + 1]), 0);
        chk("R8 wr start", r2 + 2, int'(lg_pre[r2 + 2]), 2);
    endtask

    task automatic t_write_by_write();
        int r1 = 213;
        int r2 = 214;
        issue(210, 1'b1, 0, 1'b0);
        issue(211, 1'b1, 1, 1'b0);
        wait_cyc(r2 + 14);
        chk("R6 old beat", r1, wr_enc(r1), 1);
        for (int k = 0; k < 4; k++) chk("R6 new beat", r2 + k, wr_enc(r2 + k), 2);
        chk("R6 end", r2 + 4, wr_enc(r2 + 4), 0);
        for (int k = 0; k < 12; k++) chk("R8 no ap no precharge", r1 + k, int'(lg_pre[r1 + k]), 0);
        chk("R8 cut bank idle", r2, int'(lg_idle[r2][0]), 1);
    endtask

    task automatic t_illegal();
        int r = 253;
        int r3 = 303;
        issue(250, 1'b1, 2, 1'b1);
        issue(255, 1'b0, 2, 1'b0);
        wait_cyc(r + 14);
        chk("R10 no err before", r + 4, int'(lg_err[r + 4]), 0);
        chk("R10 err pending bank", r + 5, int'(lg_err[r + 5]), 1);
        chk("R10 err one cycle", r + 6, int'(lg_err[r + 6]), 0);
        chk("R10 precharge kept", r + 6, int'(lg_pre[r + 6]), 4);
        for (int k = 5; k < 12; k++) chk("R10 refused read", r + k, rd_enc(r + k), 0);
        chk("R10 idle kept", r + 9, int'(lg_idle[r + 9][2]), 1);
        issue(300, 1'b0, 3, 1'b1);
        issue(301, 1'b0, 3, 1'b0);
        wait_cyc(r3 + 14);
        chk("R10 first ok", r3, int'(lg_err[r3]), 0);
        chk("R10 err ap burst", r3 + 1, int'(lg_err[r3 + 1]), 1);
        for (int k = 2; k < 6; k++) chk("R10 burst continues", r3 + k, rd_enc(r3 + k), 4);
        chk("R10 burst length kept", r3 + 6, rd_enc(r3 + 6), 0);
        chk("R10 precharge on time", r3 + 4, int'(lg_pre[r3 + 4]), 8);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_plain_read();
        t_write_ap();
        t_read_by_read();
        t_read_by_write();
        t_write_by_read();
        t_write_by_write();
        t_illegal();
        wait_cyc(340);
        chk("R9 all idle at end", 340, int'(lg_idle[339]), 15);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule